// File: doc/BRIEF.md
# Compare-Match Interval Timer Group

This block is a small group of interval timer channels that share one run-control register. Each channel has an up-counter fed by its own prescaler, a compare register and a control/status register. When a prescaled tick finds the counter equal to the compare value, the counter restarts from zero and a sticky match flag is set. The period is therefore compare value plus one ticks. An interrupt output per channel follows the flag while the channel's interrupt enable is set.

Software reaches the block over a simple register bus with a combinational read path. A build-time parameter selects a 16-bit variant or a 32-bit variant. In the 32-bit variant the counter and compare registers are 32 bits wide, and the control/status and run registers stay 16 bits wide. In the 32-bit variant a second sticky flag records a counter that rolls past all ones without a match. Software clears flags by writing the control register back with the flag bit at zero.

Top module: `cmt_timer_group`

## Requirements
- R1: After reset every counter and control register reads 0, every compare register reads all ones, the run register reads 0 and every interrupt output is low.
- R2: The run register sits at byte address 0. Channel c occupies the 16 bytes from (c+1)*16. Within a channel, index 0 is control, index 1 is counter and index 2 is compare, at byte offset index*4 in the 32-bit variant (index*2 in the 16-bit variant). Any other offset reads 0.
- R3: Bit c of the run register runs channel c. Only the low NUM_CH bits are stored and read back. A stopped channel's counter does not move while a sibling channel runs.
- R4: Control bits [1:0] select the prescaler: 0 gives /8, 1 gives /32, 2 gives /128 and 3 gives /512. A channel started with counter 0 holds floor(n/div) mod (compare+1) after n clock edges.
- R5: When a tick finds the counter equal to the compare value, the counter returns to 0 and the match flag is set. The match flag is control bit 15 in the 32-bit variant and bit 7 in the 16-bit variant.
- R6: A control write with the flag bit at 0 clears the match flag. A write with the flag bit at 1 leaves the flag unchanged and never sets it. All other control bits take the written value.
- R7: The interrupt output equals match flag AND the enable bit. The enable bit is control bit 5 in the 32-bit variant and bit 6 in the 16-bit variant. Writing control to 0 drops the interrupt.
- R8: The counter and compare registers can be written while the channel runs. A counter write wins over a tick in the same cycle. A new compare value is used at the next tick.
- R9: Clearing a channel's run bit freezes its counter and clears its prescaler, so after a restart the first tick comes a full divisor period later.
- R10: In the 32-bit variant, a tick on an all-ones counter that does not match sets the wrap flag (control bit 14) and the counter goes to 0. This flag is cleared the same way as the match flag and does not drive the interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access select |
| bus_we | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | NUM_CH | Per-channel interrupt request |

## Verification
Random trials vary the channel, the prescaler code (/8 or /32) and the compare value, and sample the counter and flag after a random number of edges. These trials separate an off-by-one period from a correct compare+1 period and catch a flag that sets one tick early or late. Directed cases cover the /128 and /512 codes, a compare value lowered while the channel runs, a counter write that coincides with a tick, and a stop followed by a restart, which exposes a prescaler that fails to clear. Further directed cases check the write-zero-to-clear flag rule against writes of one, the all-ones rollover that sets only the wrap flag, and the decoding of misaligned and out-of-range offsets.

// File: rtl/cmt_pkg.sv
package cmt_pkg;

  typedef enum logic [1:0] {
    REG_CTRL  = 2'd0,
    REG_COUNT = 2'd1,
    REG_MATCH = 2'd2,
    REG_NONE  = 2'd3
  } reg_sel_e;

  // Last prescaler count before a tick: divisor 8 << (2*code), minus one.
  function automatic logic [8:0] prescale_last(input logic [1:0] code);
    logic [9:0] div;
    div = 10'd8 << (2 * code);
    return 9'(div - 10'd1);
  endfunction

  // Register selected by an offset inside a channel's 16-byte window.
  function automatic reg_sel_e decode_reg(input logic [3:0] off, input logic wide);
    logic [2:0] idx;
    logic       aligned;
    if (wide) begin
      aligned = (off[1:0] == 2'b00);
      idx     = {1'b0, off[3:2]};
    end else begin
      aligned = (off[0] == 1'b0);
      idx     = off[3:1];
    end
    if (!aligned || idx > 3'd2) return REG_NONE;
    return reg_sel_e'(idx[1:0]);
  endfunction

endpackage

// File: rtl/cmt_prescaler.sv
module cmt_prescaler (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [1:0] code,
  output logic       tick
);
  import cmt_pkg::*;

  logic [8:0] pre_q;
  logic [8:0] last;

  assign last = prescale_last(code);
  assign tick = run && (pre_q == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pre_q <= '0;
    else if (!run)   pre_q <= '0;
    else if (tick)   pre_q <= '0;
    else             pre_q <= pre_q + 9'd1;
  end

  // R4
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

endmodule

// File: rtl/cmt_start_reg.sv
module cmt_start_reg #(
  parameter int NUM_CH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [NUM_CH-1:0] wdata,
  output logic [NUM_CH-1:0] run
);
  logic [NUM_CH-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   run_q <= '0;
    else if (wr)  run_q <= wdata;
  end

  assign run = run_q;

  // R3
  run_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(run_q));

endmodule

// File: rtl/cmt_channel.sv
module cmt_channel #(
  parameter bit WIDE  = 1'b1,
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             wr_ctrl,
  input  logic             wr_count,
  input  logic             wr_match,
  input  logic [CNT_W-1:0] wdata,
  output logic [15:0]      ctrl_rd,
  output logic [CNT_W-1:0] count_rd,
  output logic [CNT_W-1:0] match_rd,
  output logic             irq
);
  localparam int FLAG_BIT = WIDE ? 15 : 7;
  localparam int IE_BIT   = WIDE ? 5 : 6;
  localparam int WRAP_BIT = 14;

  logic [15:0]      ctrl_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cmp_q;
  logic             match_flag_q;
  logic             wrap_flag_q;
  logic             tick;
  logic             match_evt;
  logic             wrap_evt;

  cmt_prescaler u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .code  (ctrl_q[1:0]),
    .tick  (tick)
  );

  assign match_evt = tick && (cnt_q == cmp_q);
  assign wrap_evt  = tick && !match_evt && (cnt_q == '1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ctrl_q <= '0;
    else if (wr_ctrl)  ctrl_q <= wdata[15:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (wr_count)   cnt_q <= wdata;
    else if (match_evt)  cnt_q <= '0;
    else if (tick)       cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cmp_q <= '1;
    else if (wr_match) cmp_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             match_flag_q <= 1'b0;
    else if (match_evt)                     match_flag_q <= 1'b1;
    else if (wr_ctrl && !wdata[FLAG_BIT])   match_flag_q <= 1'b0;
  end

  generate
    if (WIDE) begin : g_wrap
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                             wrap_flag_q <= 1'b0;
        else if (wrap_evt)                      wrap_flag_q <= 1'b1;
        else if (wr_ctrl && !wdata[WRAP_BIT])   wrap_flag_q <= 1'b0;
      end
    end else begin : g_nowrap
      assign wrap_flag_q = 1'b0;
    end
  endgenerate

  always_comb begin
    ctrl_rd           = ctrl_q;
    ctrl_rd[FLAG_BIT] = match_flag_q;
    if (WIDE) ctrl_rd[WRAP_BIT] = wrap_flag_q;
  end

  assign count_rd = cnt_q;
  assign match_rd = cmp_q;
  assign irq      = match_flag_q & ctrl_q[IE_BIT];

  // R5
  match_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match_evt && !wr_count |=> cnt_q == '0);

  // R6
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match_flag_q && !(wr_ctrl && !wdata[FLAG_BIT]) |=> match_flag_q);

  // R9
  stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run && !wr_count |=> $stable(cnt_q));

  // R7
  irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl && !wdata[IE_BIT] |=> !irq);

endmodule

// File: rtl/cmt_timer_group.sv
module cmt_timer_group #(
  parameter bit WIDE   = 1'b1,
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [NUM_CH-1:0] irq
);
  import cmt_pkg::*;

  localparam int CNT_W = WIDE ? 32 : 16;

  logic              wr;
  logic              start_hit;
  logic [NUM_CH-1:0] run;
  logic [NUM_CH-1:0] ch_hit;
  reg_sel_e          ch_reg   [NUM_CH];
  logic [15:0]       ctrl_rd  [NUM_CH];
  logic [CNT_W-1:0]  count_rd [NUM_CH];
  logic [CNT_W-1:0]  match_rd [NUM_CH];

  assign wr        = bus_sel & bus_we;
  assign start_hit = (bus_addr == '0);

  cmt_start_reg #(.NUM_CH(NUM_CH)) u_start (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (wr && start_hit),
    .wdata (bus_wdata[NUM_CH-1:0]),
    .run   (run)
  );

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      assign ch_hit[c] = ((bus_addr >> 4) == ADDR_W'(c + 1));
      assign ch_reg[c] = decode_reg(bus_addr[3:0], WIDE);

      cmt_channel #(.WIDE(WIDE), .CNT_W(CNT_W)) u_ch (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run[c]),
        .wr_ctrl  (wr && ch_hit[c] && ch_reg[c] == REG_CTRL),
        .wr_count (wr && ch_hit[c] && ch_reg[c] == REG_COUNT),
        .wr_match (wr && ch_hit[c] && ch_reg[c] == REG_MATCH),
        .wdata    (bus_wdata[CNT_W-1:0]),
        .ctrl_rd  (ctrl_rd[c]),
        .count_rd (count_rd[c]),
        .match_rd (match_rd[c]),
        .irq      (irq[c])
      );
    end
  endgenerate

  always_comb begin
    bus_rdata = '0;
    if (start_hit) bus_rdata = 32'(run);
    for (int c = 0; c < NUM_CH; c++) begin
      if (ch_hit[c]) begin
        case (ch_reg[c])
          REG_CTRL:  bus_rdata = 32'(ctrl_rd[c]);
          REG_COUNT: bus_rdata = 32'(count_rd[c]);
          REG_MATCH: bus_rdata = 32'(match_rd[c]);
          default:   bus_rdata = '0;
        endcase
      end
    end
  end

endmodule

// File: tb/cmt_timer_group_bench.sv
module cmt_timer_group_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [1:0]  irq;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 0;

  cmt_timer_group u_cmt_timer_group (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] reg_addr(input int ch, input int idx);
    return 8'((ch + 1) * 16 + idx * 4);
  endfunction

  function automatic int div_of(input int code);
    return 8 << (2 * code);
  endfunction

  function automatic logic [31:0] exp_count(input int n, input int dv, input int cmp);
    return 32'((n / dv) % (cmp + 1));
  endfunction

  function automatic logic exp_flag(input int n, input int dv, input int cmp);
    return n >= dv * (cmp + 1);
  endfunction

  function automatic logic [31:0] mk_ctrl(input int code, input bit ie);
    return 32'(code) | (ie ? 32'h20 : 32'h0);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    #1;
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic peek(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic go_to(input int s, input int n);
    while (cyc - s < n) @(negedge clk);
  endtask

  task automatic setup_ch(input int ch, input int code, input bit ie, input logic [31:0] cmp,
                          input logic [31:0] cnt);
    wr(8'h00, 32'h0);
    wr(reg_addr(ch, 0), mk_ctrl(code, ie));
    wr(reg_addr(ch, 2), cmp);
    wr(reg_addr(ch, 1), cnt);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, d2, c1;
    int s, n;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    peek(8'h00, d);            check("R1 run reg", d, 32'h0);
    peek(reg_addr(0, 0), d);   check("R1 ctrl0", d, 32'h0);
    peek(reg_addr(0, 1), d);   check("R1 count0", d, 32'h0);
    peek(reg_addr(0, 2), d);   check("R1 match0", d, 32'hFFFF_FFFF);
    peek(reg_addr(1, 2), d);   check("R1 match1", d, 32'hFFFF_FFFF);
    check("R1 irq", 32'(irq), 32'h0);

    // R2 address map
    wr(reg_addr(1, 2), 32'h1234_5678);
    wr(reg_addr(1, 1), 32'hABCD_0001);
    peek(reg_addr(1, 2), d);   check("R2 match1 readback", d, 32'h1234_5678);
    peek(reg_addr(1, 1), d);   check("R2 count1 readback", d, 32'hABCD_0001);
    peek(reg_addr(0, 2), d);   check("R2 match0 untouched", d, 32'hFFFF_FFFF);
    peek(8'h2C, d);            check("R2 index3 reads 0", d, 32'h0);
    peek(8'h22, d);            check("R2 misaligned reads 0", d, 32'h0);

    // R3 run register width and per-channel gating
    wr(8'h00, 32'hFFFF);
    peek(8'h00, d);            check("R3 run readback", d, 32'h3);
    setup_ch(0, 0, 1'b0, 32'd1000, 32'd0);
    wr(reg_addr(1, 0), mk_ctrl(0, 1'b0));
    wr(reg_addr(1, 2), 32'd1000);
    wr(reg_addr(1, 1), 32'd0);
    wr(8'h00, 32'h2);
    s = cyc;
    go_to(s, 40);
    peek(reg_addr(0, 1), d);   check("R3 stopped ch0 holds", d, 32'h0);
    peek(reg_addr(1, 1), d);   check("R3 running ch1 counts", d, exp_count(cyc - s, 8, 1000));

    // R4 slow prescaler codes
    setup_ch(0, 3, 1'b0, 32'd1000, 32'd0);
    wr(8'h00, 32'h1); s = cyc;
    go_to(s, 1100);
    peek(reg_addr(0, 1), d);   check("R4 div512", d, exp_count(cyc - s, 512, 1000));
    setup_ch(0, 2, 1'b0, 32'd1000, 32'd0);
    wr(8'h00, 32'h1); s = cyc;
    go_to(s, 300);
    peek(reg_addr(0, 1), d);   check("R4 div128", d, exp_count(cyc - s, 128, 1000));

    // R5 / R7 match boundary with interrupt enabled
    setup_ch(0, 0, 1'b1, 32'd3, 32'd0);
    wr(8'h00, 32'h1); s = cyc;
    go_to(s, 31);
    peek(reg_addr(0, 0), d);   check("R5 no flag before period", d, 32'h0020);
    check("R7 irq low before match", 32'(irq[0]), 32'h0);
    go_to(s, 32);
    peek(reg_addr(0, 1), d);   check("R5 restart at zero", d, 32'h0);
    peek(reg_addr(0, 0), d);   check("R5 flag bit15 set", d, 32'h8020);
    check("R7 irq follows flag", 32'(irq[0]), 32'h1);

    // R6 flag write rules (channel stopped)
    wr(8'h00, 32'h0);
    wr(reg_addr(0, 0), 32'h8021);
    peek(reg_addr(0, 0), d);   check("R6 write1 keeps flag", d, 32'h8021);
    wr(reg_addr(0, 0), 32'h0021);
    peek(reg_addr(0, 0), d);   check("R6 write0 clears flag", d, 32'h0021);
    wr(reg_addr(0, 0), 32'h8021);
    peek(reg_addr(0, 0), d);   check("R6 write1 cannot set", d, 32'h0021);

    // R7 enable gating and drop on control write of 0
    setup_ch(0, 0, 1'b0, 32'd1, 32'd0);
    wr(8'h00, 32'h1); s = cyc;
    go_to(s, 20);
    peek(reg_addr(0, 0), d);   check("R7 flag set with ie off", d, 32'h8000);
    check("R7 irq masked", 32'(irq[0]), 32'h0);
    wr(reg_addr(0, 0), 32'h8020);
    #1;                        check("R7 irq with ie on", 32'(irq[0]), 32'h1);
    wr(reg_addr(0, 0), 32'h0);
    #1;                        check("R7 irq drops on ctrl 0", 32'(irq[0]), 32'h0);

    // R8 live compare and counter writes
    setup_ch(0, 0, 1'b0, 32'd100, 32'd0);
    wr(8'h00, 32'h1); s = cyc;
    go_to(s, 40);
    wr(reg_addr(0, 2), 32'd7);
    go_to(s, 70);
    peek(reg_addr(0, 1), d);   check("R8 new compare used", d, 32'h0);
    peek(reg_addr(0, 0), d);   check("R8 flag from new compare", d, 32'h8000);
    wr(reg_addr(0, 1), 32'd50);
    peek(reg_addr(0, 1), d);   check("R8 live counter write", d, 32'd50);

    // R9 stop freezes counter, restart clears prescaler
    wr(8'h00, 32'h0);
    peek(reg_addr(0, 1), c1);
    repeat (50) @(negedge clk);
    peek(reg_addr(0, 1), d);   check("R9 frozen while stopped", d, c1);
    wr(8'h00, 32'h1); s = cyc;
    go_to(s, 7);
    peek(reg_addr(0, 1), d);   check("R9 no tick before full period", d, c1);
    go_to(s, 20);
    peek(reg_addr(0, 1), d);   check("R9 resumes after restart", d, c1 + 32'd2);

    // R10 all-ones rollover sets wrap flag only
    setup_ch(0, 0, 1'b0, 32'd5, 32'hFFFF_FFFE);
    wr(8'h00, 32'h1); s = cyc;
    go_to(s, 8);
    peek(reg_addr(0, 1), d);   check("R10 reaches all ones", d, 32'hFFFF_FFFF);
    go_to(s, 16);
    peek(reg_addr(0, 1), d);   check("R10 rolls to zero", d, 32'h0);
    peek(reg_addr(0, 0), d);   check("R10 wrap flag only", d, 32'h4000);
    check("R10 no irq from wrap", 32'(irq[0]), 32'h0);
    wr(reg_addr(0, 0), 32'h0);
    peek(reg_addr(0, 0), d);   check("R10 wrap flag cleared", d, 32'h0);

    // R4 / R5 / R7 random trials
    for (int i = 0; i < 10; i++) begin
      int ch, code, cmp, dv, nw;
      ch   = int'($urandom % 2);
      code = int'($urandom % 2);
      cmp  = int'($urandom % 13);
      dv   = div_of(code);
      nw   = int'($urandom % (dv * (cmp + 1) * 2 + 1));
      setup_ch(ch, code, 1'b1, 32'(cmp), 32'd0);
      wr(8'h00, 32'(1 << ch)); s = cyc;
      go_to(s, nw);
      n = cyc - s;
      peek(reg_addr(ch, 1), d);
      check("R4 random count", d, exp_count(n, dv, cmp));
      peek(reg_addr(ch, 0), d2);
      check("R5 random flag", 32'(d2[15]), 32'(exp_flag(n, dv, cmp)));
      check("R7 random irq", 32'(irq[ch]), 32'(exp_flag(n, dv, cmp)));
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule